// File: doc/BRIEF.md
# Phase Lock Window Detector

This block decides whether a feedback clock is phase-aligned with a reference clock. Both clocks arrive already sampled by a fast sampling clock. Each sample period is one tick, and every distance is measured in ticks. On each selected edge of the reference, the block looks for the nearest feedback edge of the same polarity, on either side. It gives an in-window verdict when that edge is no farther away than the current window, and an out-of-window verdict otherwise. A run of consecutive in-window verdicts raises the lock output. A single miss drops it.

All controls are three-level codes. The frequency-range code picks a wide window or a narrow one. The edge code picks rising or falling edges. The power code clears the detector whenever it is LOW. The test code, together with the power code, decides whether the lock output may be trusted. A separate timeout flag reports that lock was never reached within a programmable number of ticks after detection started.

Top module: `plw_lock_detect`

## Requirements
- R1: While rst_n is low, lock and lock_timeout are 0 after the next clock.
- R2: Each three-level code is two bits: 00 is LOW, 01 is MID, 10 is HIGH, and 11 is treated as MID.
- R3: With edge_code LOW, falling edges of both clocks are compared. With any other edge_code, rising edges are compared.
- R4: The separation is the tick distance from a selected reference edge to the nearest selected feedback edge, before or after it. A feedback edge in the same tick counts as 0. The verdict is in-window when this distance is at most WIN_WIDE_TICKS (range_code LOW or MID) or WIN_NARROW_TICKS (range_code HIGH).
- R5: If no feedback edge lies within the window around a reference edge, including when feedback is absent, an out-of-window verdict is given the window's width in ticks after that reference edge.
- R6: lock rises on the clock after the QUAL_LEN-th consecutive in-window verdict.
- R7: An out-of-window verdict clears lock on the following clock and restarts the consecutive count from zero.
- R8: On every clock where pwr_code is LOW, the verdict history, the consecutive count, lock and lock_timeout are all cleared.
- R9: lock_valid is 1 exactly when pwr_code is MID or HIGH and test_code is LOW. It follows these inputs without delay.
- R10: Once TIMEOUT_TICKS clocks have passed since detection started, with pwr_code not LOW and lock never yet high, lock_timeout rises. It stays high until pwr_code is LOW or reset is applied. It never rises once lock has been high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (one tick per period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_smp | input | 1 | Sampled reference clock |
| fb_smp | input | 1 | Sampled feedback clock |
| range_code | input | 2 | Frequency-range code; HIGH selects the narrow window |
| edge_code | input | 2 | Edge-polarity code; LOW selects falling edges |
| pwr_code | input | 2 | Power code; LOW clears the detector |
| test_code | input | 2 | Test-mode code; anything but LOW marks lock as not valid |
| lock | output | 1 | Phase-lock indication |
| lock_valid | output | 1 | Lock output may be trusted in the present mode |
| lock_timeout | output | 1 | Lock was not reached within the timeout |

## Verification
The feedback clock is driven at lag offsets and at lead offsets. Each is placed exactly on the window edge and one tick beyond it, for both the wide and the narrow window. These runs show whether the distance is measured to the nearest edge on either side and whether the comparison is inclusive. Waveforms whose rising edges agree but whose falling edges differ, and the reverse, show that the edge code really selects the polarity. Runs with the feedback removed, a one-period phase glitch inside a locked run, and power-down pulses show the difference between a missed verdict, a restarted count and a full clear. A feedback-less run that lasts past the timeout, followed by recovery, shows that the timeout flag stays set until it is cleared.

// File: rtl/plw_pkg.sv
package plw_pkg;

   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10,
      LVL_OPEN = 2'b11
   } lvl_e;

   // The open code (11) behaves as MID, so only LOW and HIGH need a test.
   function automatic logic lvl_is_low(input logic [1:0] code);
      return code == LVL_LOW;
   endfunction

   function automatic logic lvl_is_high(input logic [1:0] code);
      return code == LVL_HIGH;
   endfunction

endpackage

// File: rtl/plw_edge_det.sv
module plw_edge_det #(
   parameter int CHANNELS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_sel,
   input  logic [CHANNELS-1:0] sig_in,
   output logic [CHANNELS-1:0] edge_out
);

   logic [CHANNELS-1:0] prev_q;

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      logic rise_w;
      logic fall_w;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[ch] <= 1'b0;
         else        prev_q[ch] <= sig_in[ch];
      end

      assign rise_w       = sig_in[ch] & ~prev_q[ch];
      assign fall_w       = ~sig_in[ch] & prev_q[ch];
      assign edge_out[ch] = fall_sel ? fall_w : rise_w;
   end

endmodule

// File: rtl/plw_phase_meas.sv
module plw_phase_meas #(
   parameter int WIN_WIDE   = 16,
   parameter int WIN_NARROW = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic narrow_sel,
   input  logic ref_edge,
   input  logic fb_edge,
   output logic in_win,
   output logic out_win
);

   localparam int CW = $clog2(WIN_WIDE + 2);
   localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};

   logic [CW-1:0] win;
   logic [CW-1:0] age_q, age_d;   // ticks since the latest feedback edge
   logic [CW-1:0] lag_q, lag_d;   // ticks since an unmatched reference edge
   logic          pend_q, pend_d;
   logic          in_raw, out_raw;

   if (WIN_WIDE == WIN_NARROW) begin : g_fixed_win
      assign win = CW'(WIN_WIDE);
   end else begin : g_sel_win
      assign win = narrow_sel ? CW'(WIN_NARROW) : CW'(WIN_WIDE);
   end

   always_comb begin
      in_raw  = 1'b0;
      out_raw = 1'b0;
      pend_d  = pend_q;
      lag_d   = lag_q;
      if (pend_q) begin
         if (fb_edge) begin
            in_raw = 1'b1;
            pend_d = 1'b0;
         end else if (ref_edge || lag_q >= win) begin
            out_raw = 1'b1;
            pend_d  = 1'b0;
         end else begin
            lag_d = lag_q + 1'b1;
         end
      end else if (ref_edge) begin
         if (fb_edge || age_q <= win) begin
            in_raw = 1'b1;
         end else begin
            pend_d = 1'b1;
            lag_d  = CW'(1);
         end
      end
      if (fb_edge)              age_d = CW'(1);
      else if (age_q == AGE_MAX) age_d = AGE_MAX;
      else                      age_d = age_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q  <= AGE_MAX;
         lag_q  <= '0;
         pend_q <= 1'b0;
      end else if (clear) begin
         age_q  <= AGE_MAX;
         lag_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         age_q  <= age_d;
         lag_q  <= lag_d;
         pend_q <= pend_d;
      end
   end

   assign in_win  = in_raw  & ~clear;
   assign out_win = out_raw & ~clear;

endmodule

// File: rtl/plw_qualifier.sv
module plw_qualifier #(
   parameter int QUAL_LEN      = 16,
   parameter int TIMEOUT_TICKS = 5000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic in_win,
   input  logic out_win,
   output logic lock,
   output logic timeout
);

   localparam int TW = $clog2(TIMEOUT_TICKS + 1);

   logic          lock_q, lock_d;
   logic          seen_q;
   logic          tout_q, tout_d;
   logic [TW-1:0] tcnt_q, tcnt_d;

   if (QUAL_LEN == 1) begin : g_single
      always_comb begin
         if (out_win)     lock_d = 1'b0;
         else if (in_win) lock_d = 1'b1;
         else             lock_d = lock_q;
      end
   end else begin : g_count
      localparam int QW = $clog2(QUAL_LEN + 1);
      logic [QW-1:0] cnt_q, cnt_d;

      always_comb begin
         cnt_d  = cnt_q;
         lock_d = lock_q;
         if (out_win) begin
            cnt_d  = '0;
            lock_d = 1'b0;
         end else if (in_win) begin
            if (cnt_q != QW'(QUAL_LEN)) cnt_d = cnt_q + 1'b1;
            if (cnt_q >= QW'(QUAL_LEN - 1)) lock_d = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (clear) cnt_q <= '0;
         else            cnt_q <= cnt_d;
      end
   end

   always_comb begin
      tcnt_d = tcnt_q;
      tout_d = tout_q;
      if (!(seen_q || lock_q) && !tout_q) begin
         if (tcnt_q == TW'(TIMEOUT_TICKS - 1)) tout_d = 1'b1;
         else                                  tcnt_d = tcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         seen_q <= 1'b0;
         tout_q <= 1'b0;
         tcnt_q <= '0;
      end else if (clear) begin
         lock_q <= 1'b0;
         seen_q <= 1'b0;
         tout_q <= 1'b0;
         tcnt_q <= '0;
      end else begin
         lock_q <= lock_d;
         seen_q <= seen_q | lock_q;
         tout_q <= tout_d;
         tcnt_q <= tcnt_d;
      end
   end

   assign lock    = lock_q;
   assign timeout = tout_q;

endmodule

// File: rtl/plw_lock_detect.sv
module plw_lock_detect
   import plw_pkg::*;
#(
   parameter int WIN_WIDE_TICKS   = 16,
   parameter int WIN_NARROW_TICKS = 8,
   parameter int QUAL_LEN         = 16,
   parameter int TIMEOUT_TICKS    = 5000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_smp,
   input  logic       fb_smp,
   input  logic [1:0] range_code,
   input  logic [1:0] edge_code,
   input  logic [1:0] pwr_code,
   input  logic [1:0] test_code,
   output logic       lock,
   output logic       lock_valid,
   output logic       lock_timeout
);

   localparam int CH_REF = 0;
   localparam int CH_FB  = 1;

   if (WIN_NARROW_TICKS < 1 || WIN_NARROW_TICKS > WIN_WIDE_TICKS) begin : g_bad_window
      $error("plw_lock_detect: narrow window must be 1..WIN_WIDE_TICKS");
   end
   if (QUAL_LEN < 1) begin : g_bad_qual
      $error("plw_lock_detect: QUAL_LEN must be at least 1");
   end
   if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
      $error("plw_lock_detect: TIMEOUT_TICKS must be at least 2");
   end

   logic       clear;
   logic [1:0] edges;
   logic       in_win, out_win;

   assign clear = lvl_is_low(pwr_code);

   plw_edge_det #(.CHANNELS(2)) u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_sel (lvl_is_low(edge_code)),
      .sig_in   ({fb_smp, ref_smp}),
      .edge_out (edges)
   );

   plw_phase_meas #(
      .WIN_WIDE   (WIN_WIDE_TICKS),
      .WIN_NARROW (WIN_NARROW_TICKS)
   ) u_meas (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .narrow_sel (lvl_is_high(range_code)),
      .ref_edge   (edges[CH_REF]),
      .fb_edge    (edges[CH_FB]),
      .in_win     (in_win),
      .out_win    (out_win)
   );

   plw_qualifier #(
      .QUAL_LEN      (QUAL_LEN),
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .in_win  (in_win),
      .out_win (out_win),
      .lock    (lock),
      .timeout (lock_timeout)
   );

   assign lock_valid = !clear && lvl_is_low(test_code);

endmodule

// File: rtl/plw_lock_detect_chk.sv
module plw_lock_detect_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pwr_code,
   input logic [1:0] test_code,
   input logic       lock,
   input logic       lock_valid,
   input logic       lock_timeout
);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!lock && !lock_timeout));

   // R8
   pwrdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_code == 2'b00) |=> (!lock && !lock_timeout));

   // R9
   test_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code != 2'b00) |-> !lock_valid);

   // R9
   pwrdown_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_code == 2'b00) |-> !lock_valid);

   // R6
   lock_rise_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> ($past(pwr_code) != 2'b00));

   // R10
   timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_timeout && pwr_code != 2'b00) |=> lock_timeout);

   // R10
   timeout_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_timeout) |-> !$past(lock));

endmodule

bind plw_lock_detect plw_lock_detect_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_code     (pwr_code),
   .test_code    (test_code),
   .lock         (lock),
   .lock_valid   (lock_valid),
   .lock_timeout (lock_timeout)
);

// File: tb/plw_lock_detect_tb.sv
module plw_lock_detect_tb;

   localparam int WW = 4;
   localparam int WN = 2;
   localparam int Q  = 6;
   localparam int T  = 200;
   localparam int CAP = 1000;
   localparam int PER = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_smp = 1'b0;
   logic       fb_smp = 1'b0;
   logic [1:0] range_code = 2'b01;
   logic [1:0] edge_code = 2'b01;
   logic [1:0] pwr_code = 2'b01;
   logic [1:0] test_code = 2'b00;
   logic       lock, lock_valid, lock_timeout;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   plw_lock_detect #(
      .WIN_WIDE_TICKS   (WW),
      .WIN_NARROW_TICKS (WN),
      .QUAL_LEN         (Q),
      .TIMEOUT_TICKS    (T)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_smp      (ref_smp),
      .fb_smp       (fb_smp),
      .range_code   (range_code),
      .edge_code    (edge_code),
      .pwr_code     (pwr_code),
      .test_code    (test_code),
      .lock         (lock),
      .lock_valid   (lock_valid),
      .lock_timeout (lock_timeout)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference model, updated on every sampling edge
   int m_rp = 0, m_fp = 0, m_age = CAP, m_pend = 0, m_lag = 0, m_cnt = 0;
   int m_lock = 0, m_seen = 0, m_tc = 0, m_to = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rp = 0; m_fp = 0; m_age = CAP; m_pend = 0; m_lag = 0; m_cnt = 0;
         m_lock = 0; m_seen = 0; m_tc = 0; m_to = 0;
      end else begin
         int re, fe, w, vin, vout, o_lock, o_seen;
         if (edge_code == 2'b00) begin
            re = (!ref_smp && m_rp == 1) ? 1 : 0;
            fe = (!fb_smp && m_fp == 1) ? 1 : 0;
         end else begin
            re = (ref_smp && m_rp == 0) ? 1 : 0;
            fe = (fb_smp && m_fp == 0) ? 1 : 0;
         end
         w = (range_code == 2'b10) ? WN : WW;
         if (pwr_code == 2'b00) begin
            m_age = CAP; m_pend = 0; m_lag = 0; m_cnt = 0;
            m_lock = 0; m_seen = 0; m_tc = 0; m_to = 0;
         end else begin
            vin = 0; vout = 0; o_lock = m_lock; o_seen = m_seen;
            if (m_pend == 1) begin
               if (fe == 1) begin vin = 1; m_pend = 0; end
               else if (re == 1 || m_lag >= w) begin vout = 1; m_pend = 0; end
               else m_lag++;
            end else if (re == 1) begin
               if (fe == 1 || m_age <= w) vin = 1;
               else begin m_pend = 1; m_lag = 1; end
            end
            m_age = (fe == 1) ? 1 : ((m_age < CAP) ? m_age + 1 : CAP);
            if (vout == 1) begin m_cnt = 0; m_lock = 0; end
            else if (vin == 1) begin
               if (m_cnt < Q) m_cnt++;
               if (m_cnt >= Q) m_lock = 1;
            end
            if (o_seen == 0 && o_lock == 0 && m_to == 0) begin
               if (m_tc == T - 1) m_to = 1;
               else m_tc++;
            end
            m_seen = (o_seen == 1 || o_lock == 1) ? 1 : 0;
         end
         m_rp = ref_smp; m_fp = fb_smp;
      end
   end

   always @(negedge clk) begin
      check(cur_req, "lock(model)", lock, m_lock[0]);
      check(cur_req, "lock_timeout(model)", lock_timeout, m_to[0]);
      check("R9", "lock_valid(model)", lock_valid, (pwr_code != 2'b00) && (test_code == 2'b00));
   end

   task automatic run(input int periods, input int off, input int fb_hi, input bit fb_on);
      for (int i = 0; i < periods * PER; i++) begin
         int ph;
         @(posedge clk); #2;
         ref_smp = ((i % PER) < PER / 2);
         ph = (((i - off) % PER) + PER) % PER;
         fb_smp = fb_on && (ph < fb_hi);
      end
   endtask

   task automatic set_pwr(input logic [1:0] p);
      @(posedge clk); #2;
      pwr_code = p;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "lock in reset", lock, 1'b0);
      check("R1", "timeout in reset", lock_timeout, 1'b0);
      @(posedge clk); #2; rst_n = 1'b1;

      cur_req = "R6";
      run(5, 0, 10, 1); @(negedge clk);
      check("R6", "lock after 5 verdicts", lock, 1'b0);
      run(1, 0, 10, 1); @(negedge clk);
      check("R6", "lock after 6 verdicts", lock, 1'b1);

      cur_req = "R4"; range_code = 2'b00;
      run(4, 4, 10, 1); @(negedge clk);
      check("R4", "lag at window edge", lock, 1'b1);
      run(3, 5, 10, 1); @(negedge clk);
      check("R4", "lag past window", lock, 1'b0);
      run(8, -4, 10, 1); @(negedge clk);
      check("R4", "lead at window edge", lock, 1'b1);
      run(3, -5, 10, 1); @(negedge clk);
      check("R4", "lead past window", lock, 1'b0);

      cur_req = "R2"; range_code = 2'b11;
      run(8, 4, 10, 1); @(negedge clk);
      check("R2", "open range code acts as MID", lock, 1'b1);

      cur_req = "R4"; range_code = 2'b10;
      run(3, 3, 10, 1); @(negedge clk);
      check("R4", "narrow window exceeded", lock, 1'b0);
      run(8, 2, 10, 1); @(negedge clk);
      check("R4", "narrow window edge", lock, 1'b1);

      cur_req = "R3"; range_code = 2'b01; edge_code = 2'b00;
      run(8, 0, 17, 1); @(negedge clk);
      check("R3", "falling edges 7 apart", lock, 1'b0);
      edge_code = 2'b01;
      run(8, 0, 17, 1); @(negedge clk);
      check("R3", "rising edges aligned", lock, 1'b1);
      edge_code = 2'b00;
      run(8, 7, 3, 1); @(negedge clk);
      check("R3", "falling aligned, rising apart", lock, 1'b1);

      cur_req = "R7"; edge_code = 2'b01;
      run(8, 0, 10, 1);
      run(1, 8, 10, 1); @(negedge clk);
      check("R7", "single miss drops lock", lock, 1'b0);
      run(5, 0, 10, 1); @(negedge clk);
      check("R7", "count restarted", lock, 1'b0);
      run(1, 0, 10, 1); @(negedge clk);
      check("R7", "relock after full run", lock, 1'b1);

      cur_req = "R8"; pwr_code = 2'b00;
      run(1, 0, 10, 1); @(negedge clk);
      check("R8", "power-down clears lock", lock, 1'b0);
      check("R9", "power-down invalid", lock_valid, 1'b0);
      pwr_code = 2'b10;
      run(8, 0, 10, 1); @(negedge clk);
      check("R8", "relock after power-down", lock, 1'b1);
      check("R9", "valid with HIGH power code", lock_valid, 1'b1);

      cur_req = "R9";
      for (int p = 0; p < 4; p++) begin
         for (int t = 0; t < 4; t++) begin
            @(posedge clk); #2;
            pwr_code = 2'(p); test_code = 2'(t);
            @(negedge clk);
            check("R9", "valid table", lock_valid, (p != 0) && (t == 0));
         end
      end
      @(posedge clk); #2; test_code = 2'b00; pwr_code = 2'b00;

      cur_req = "R10";
      set_pwr(2'b01);
      run(7, 0, 10, 0); @(negedge clk);
      check("R10", "timeout not yet", lock_timeout, 1'b0);
      check("R5", "no feedback, no lock", lock, 1'b0);
      run(5, 0, 10, 0); @(negedge clk);
      check("R10", "timeout raised", lock_timeout, 1'b1);
      run(8, 0, 10, 1); @(negedge clk);
      check("R10", "timeout sticky after lock", lock_timeout, 1'b1);
      check("R6", "lock after recovery", lock, 1'b1);
      cur_req = "R5";
      run(2, 0, 10, 0); @(negedge clk);
      check("R5", "feedback lost drops lock", lock, 1'b0);
      cur_req = "R10";
      set_pwr(2'b00);
      @(posedge clk); @(negedge clk);
      check("R10", "power-down clears timeout", lock_timeout, 1'b0);
      set_pwr(2'b01);
      run(12, 0, 10, 1); @(negedge clk);
      check("R10", "no timeout once locked", lock_timeout, 1'b0);
      check("R6", "locked at end", lock, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule